// File: doc/BRIEF.md
# Extended parallel port host register decoder

This block is the host-facing register file of an extended-capabilities parallel port. A host issues byte reads and writes on an ISA-style bus; the block subtracts a programmable base address from the bus address, and the resulting offset, together with a three-bit mode field held in an extended control register, picks the register that the access reaches. The same offset can therefore mean a plain data latch, the input of a byte queue, or a configuration register, depending on the mode.

In the legacy modes the data latch drives the eight peripheral data pins, and reading the data offset returns the live pin levels. In the queued modes, host writes are pushed into one shared queue of 9-bit entries. Each entry carries a tag bit that separates address/run-length bytes from data bytes. A peripheral-side engine drains the queue through a simple valid/pop port. In the test mode the host drains the same queue itself. Any access made while the address-enable qualifier is high is ignored.

Top module: `lpt_regdec`

## Requirements
- R1: After reset the data latch, the control register, configuration register B and the read-data output are 0x00, the mode is 000, the queue is empty, `pd_oe` is 1 and a read of offset +402h returns 0x01.
- R2: While `host_aen` is 1, a write changes no register and no queue contents, and a read returns 0x00.
- R3: In modes 000 and 001, a write to offset +000h loads the data latch, which drives `pd_out` non-inverted, and a read of +000h returns `pd_in`. In every other mode, a write to +000h leaves `pd_out` unchanged.
- R4: Offsets +001h (returns `stat_in`), +002h (control, read/write) and +402h are reachable in every mode. At +402h, bits 7:5 hold the mode and bits 4:2 are read/write. Bit 1 reads as queue full and bit 0 reads as queue empty.
- R5: In mode 011, a write to +000h enqueues the byte with tag 1, but only while control bit 5 is 0. While control bit 5 is 1, the write is discarded.
- R6: A write to +400h in modes 010, 011 and 110 enqueues the byte with tag 0.
- R7: The queue holds FIFO_DEPTH (16) entries and presents them on `q_data`/`q_tag` in write order. `q_valid` is 1 while the queue is not empty, and `q_pop` removes the head entry.
- R8: A write that would enqueue into a full queue is discarded. `fifo_drop` is 1 during the cycle of that write's strobe edge.
- R9: In mode 110, a read of +400h removes and returns the head byte, or returns 0x00 if the queue is empty. `q_pop` is ignored in this mode.
- R10: In mode 111, +400h reads as the constant CFGA_VAL and ignores writes, and +401h is a read/write register.
- R11: Any offset and mode combination not listed above ignores writes and reads as 0x00. This includes +401h outside mode 111 and reads of +000h in mode 011.
- R12: A host enqueue and a `q_pop` in the same cycle, on a queue that is neither empty nor full, remove the head and append the new entry. The occupancy does not change.
- R13: `pd_oe` is 0 only in mode 001 while control bit 5 is 1.
- R14: Each access takes effect once, at the first clock where its strobe is seen high. `host_rdata` is captured at that clock and held until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | ADDR_W | Port base address |
| host_aen | input | 1 | Address-enable qualifier, high blocks all access |
| host_addr | input | ADDR_W | Host address |
| host_wr | input | 1 | Write strobe, active high |
| host_rd | input | 1 | Read strobe, active high |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Captured read data |
| stat_in | input | 8 | Status byte returned at +001h |
| pd_in | input | 8 | Peripheral data pin levels |
| pd_out | output | 8 | Data latch driving the pins |
| pd_oe | output | 1 | Pin output enable |
| q_pop | input | 1 | Peripheral-side dequeue |
| q_valid | output | 1 | Queue not empty |
| q_data | output | 8 | Head byte |
| q_tag | output | 1 | Head tag, 1 = address/run-length |
| fifo_drop | output | 1 | Enqueue discarded on a full queue |

## Verification
The two functions that can land in the same cycle are a host enqueue and a peripheral dequeue. The bench provokes this by raising a write strobe to the address-queue offset in the same cycle as `q_pop`, with three entries already queued. It then judges the result by draining the queue and comparing the tag and byte sequence against a bench-side model queue. Full-queue collisions are also provoked: the bench fills all sixteen slots with alternating tags, samples `fifo_drop` before the clock edge of the seventeenth write, and confirms that the drain sequence is unchanged.

// File: rtl/lpt_regdec_pkg.sv
package lpt_regdec_pkg;

  typedef enum logic [2:0] {
    MODE_STD   = 3'b000,
    MODE_BIDIR = 3'b001,
    MODE_PFIFO = 3'b010,
    MODE_ECP   = 3'b011,
    MODE_EPP   = 3'b100,
    MODE_RSV   = 3'b101,
    MODE_TEST  = 3'b110,
    MODE_CFG   = 3'b111
  } lpt_mode_e;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_DATA,
    SEL_AFIFO,
    SEL_STAT,
    SEL_CTRL,
    SEL_PFIFO,
    SEL_EFIFO,
    SEL_TFIFO,
    SEL_CFGA,
    SEL_CFGB,
    SEL_ECR
  } lpt_sel_e;

  localparam int unsigned OFF_DATA = 32'h000;
  localparam int unsigned OFF_STAT = 32'h001;
  localparam int unsigned OFF_CTRL = 32'h002;
  localparam int unsigned OFF_HIQ  = 32'h400;
  localparam int unsigned OFF_CFGB = 32'h401;
  localparam int unsigned OFF_ECR  = 32'h402;

  localparam int unsigned CTRL_DIR_BIT = 5;

  typedef struct packed {
    logic       tag;
    logic [7:0] val;
  } q_entry_t;

endpackage

// File: rtl/lpt_addr_dec.sv
module lpt_addr_dec
  import lpt_regdec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              aen,
  input  lpt_mode_e         mode,
  output lpt_sel_e          sel
);

  logic [ADDR_W-1:0] off;

  assign off = addr - base;

  always_comb begin
    sel = SEL_NONE;
    if (aen) begin
      sel = SEL_NONE;
    end else if (off == ADDR_W'(OFF_STAT)) begin
      sel = SEL_STAT;
    end else if (off == ADDR_W'(OFF_CTRL)) begin
      sel = SEL_CTRL;
    end else if (off == ADDR_W'(OFF_ECR)) begin
      sel = SEL_ECR;
    end else if (off == ADDR_W'(OFF_DATA)) begin
      case (mode)
        MODE_STD, MODE_BIDIR: sel = SEL_DATA;
        MODE_ECP:             sel = SEL_AFIFO;
        default:              sel = SEL_NONE;
      endcase
    end else if (off == ADDR_W'(OFF_HIQ)) begin
      case (mode)
        MODE_PFIFO: sel = SEL_PFIFO;
        MODE_ECP:   sel = SEL_EFIFO;
        MODE_TEST:  sel = SEL_TFIFO;
        MODE_CFG:   sel = SEL_CFGA;
        default:    sel = SEL_NONE;
      endcase
    end else if (off == ADDR_W'(OFF_CFGB) && mode == MODE_CFG) begin
      sel = SEL_CFGB;
    end
  end

endmodule

// File: rtl/lpt_tag_fifo.sv
module lpt_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full,
  output logic         drop
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          push_ok, pop_ok;

  assign empty    = (count_q == '0);
  assign full     = (count_q == CW'(DEPTH));
  assign push_ok  = push && !full;
  assign pop_ok   = pop && !empty;
  assign drop     = push && full;
  assign pop_data = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop_ok) begin
      rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push_ok, pop_ok})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) begin
      mem[wr_ptr_q] <= push_data;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH)); // R7
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full); // R8
  AST_PUSH_POP_BAL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> $stable(count_q)); // R12
  AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty) |=> empty); // R7

endmodule

// File: rtl/lpt_regdec.sv
module lpt_regdec
  import lpt_regdec_pkg::*;
#(
  parameter int         ADDR_W     = 16,
  parameter int         FIFO_DEPTH = 16,
  parameter logic [7:0] CFGA_VAL   = 8'h14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              host_aen,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [7:0]        host_wdata,
  output logic [7:0]        host_rdata,
  input  logic [7:0]        stat_in,
  input  logic [7:0]        pd_in,
  output logic [7:0]        pd_out,
  output logic              pd_oe,
  input  logic              q_pop,
  output logic              q_valid,
  output logic [7:0]        q_data,
  output logic              q_tag,
  output logic              fifo_drop
);

  localparam int QW = $bits(q_entry_t);

  // strobe edge detection
  logic wr_q, rd_q, wr_rise, rd_rise;

  // register file state
  logic [7:0] data_q, data_d;
  logic [7:0] ctrl_q, ctrl_d;
  logic [5:0] ecr_hi_q, ecr_hi_d;
  logic [7:0] cfgb_q, cfgb_d;
  logic [7:0] rdata_q, rdata_d;

  lpt_mode_e mode;
  lpt_sel_e  sel;
  logic      dir_rev;

  // queue interface
  q_entry_t  push_ent, head_ent;
  logic      q_push, q_pop_any, host_pop;
  logic      q_empty, q_full, q_drop;
  logic [7:0] rd_val;

  assign wr_rise = host_wr && !wr_q;
  assign rd_rise = host_rd && !rd_q;
  assign mode    = lpt_mode_e'(ecr_hi_q[5:3]);
  assign dir_rev = ctrl_q[CTRL_DIR_BIT];

  lpt_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (host_addr),
    .base (cfg_base),
    .aen  (host_aen),
    .mode (mode),
    .sel  (sel)
  );

  // enqueue / dequeue steering
  always_comb begin
    q_push       = 1'b0;
    push_ent.tag = 1'b0;
    push_ent.val = host_wdata;
    if (wr_rise) begin
      case (sel)
        SEL_AFIFO: begin
          q_push       = !dir_rev;
          push_ent.tag = 1'b1;
        end
        SEL_PFIFO, SEL_EFIFO, SEL_TFIFO: q_push = 1'b1;
        default: q_push = 1'b0;
      endcase
    end
  end

  assign host_pop  = rd_rise && (sel == SEL_TFIFO);
  assign q_pop_any = host_pop || (q_pop && (mode != MODE_TEST));

  lpt_tag_fifo #(.DEPTH(FIFO_DEPTH), .W(QW)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (q_push),
    .push_data (push_ent),
    .pop       (q_pop_any),
    .pop_data  (head_ent),
    .empty     (q_empty),
    .full      (q_full),
    .drop      (q_drop)
  );

  // read multiplexer
  always_comb begin
    case (sel)
      SEL_DATA:  rd_val = pd_in;
      SEL_STAT:  rd_val = stat_in;
      SEL_CTRL:  rd_val = ctrl_q;
      SEL_ECR:   rd_val = {ecr_hi_q, q_full, q_empty};
      SEL_TFIFO: rd_val = q_empty ? 8'h00 : head_ent.val;
      SEL_CFGA:  rd_val = CFGA_VAL;
      SEL_CFGB:  rd_val = cfgb_q;
      default:   rd_val = 8'h00;
    endcase
  end

  // next-state for the register file
  always_comb begin
    data_d   = data_q;
    ctrl_d   = ctrl_q;
    ecr_hi_d = ecr_hi_q;
    cfgb_d   = cfgb_q;
    rdata_d  = rdata_q;
    if (wr_rise) begin
      case (sel)
        SEL_DATA: data_d   = host_wdata;
        SEL_CTRL: ctrl_d   = host_wdata;
        SEL_ECR:  ecr_hi_d = host_wdata[7:2];
        SEL_CFGB: cfgb_d   = host_wdata;
        default:  ;
      endcase
    end
    if (rd_rise) begin
      rdata_d = rd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b0;
      rd_q     <= 1'b0;
      data_q   <= 8'h00;
      ctrl_q   <= 8'h00;
      ecr_hi_q <= 6'h00;
      cfgb_q   <= 8'h00;
      rdata_q  <= 8'h00;
    end else begin
      wr_q     <= host_wr;
      rd_q     <= host_rd;
      data_q   <= data_d;
      ctrl_q   <= ctrl_d;
      ecr_hi_q <= ecr_hi_d;
      cfgb_q   <= cfgb_d;
      rdata_q  <= rdata_d;
    end
  end

  assign host_rdata = rdata_q;
  assign pd_out     = data_q;
  assign pd_oe      = !((mode == MODE_BIDIR) && dir_rev);
  assign q_valid    = !q_empty;
  assign q_data     = head_ent.val;
  assign q_tag      = head_ent.tag;
  assign fifo_drop  = q_drop;

  AST_AEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    host_aen |=> (data_q == $past(data_q) && ecr_hi_q == $past(ecr_hi_q)
                  && cfgb_q == $past(cfgb_q) && ctrl_q == $past(ctrl_q))); // R2
  AST_DATA_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mode inside {MODE_STD, MODE_BIDIR}) |=> $stable(data_q)); // R3
  AST_CFG_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_CFGA || sel == SEL_CFGB) |-> mode == MODE_CFG); // R10
  AST_TEST_NOPOP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TEST && q_valid && !wr_rise && !rd_rise) |=> $stable(q_data)); // R9
  AST_RD_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && rd_q) |=> $stable(host_rdata)); // R14

endmodule

// File: tb/lpt_regdec_tb.sv
`timescale 1ns/1ps
module lpt_regdec_tb;

  localparam logic [15:0] BASE = 16'h0378;
  localparam logic [7:0]  CFGA = 8'h14;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_aen, host_wr, host_rd, q_pop;
  logic [15:0] host_addr;
  logic [7:0]  host_wdata, stat_in, pd_in;
  logic [7:0]  host_rdata, pd_out, q_data;
  logic        pd_oe, q_valid, q_tag, fifo_drop;

  int checks = 0;
  int errors = 0;
  logic [8:0] mq [$];
  logic [7:0] data_exp, cfgb_exp, v;

  always #2 clk = ~clk;

  lpt_regdec #(.ADDR_W(16), .FIFO_DEPTH(16), .CFGA_VAL(CFGA)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base(BASE), .host_aen(host_aen),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .stat_in(stat_in),
    .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .q_pop(q_pop),
    .q_valid(q_valid), .q_data(q_data), .q_tag(q_tag), .fifo_drop(fifo_drop)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] off, input logic [7:0] d);
    @(negedge clk);
    host_addr = BASE + off; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] off, output logic [7:0] d);
    @(negedge clk);
    host_addr = BASE + off; host_rd = 1'b1;
    @(negedge clk);
    d = host_rdata; host_rd = 1'b0;
  endtask

  task automatic pop1();
    @(negedge clk); q_pop = 1'b1;
    @(negedge clk); q_pop = 1'b0;
  endtask

  task automatic drain(input string req);
    logic [8:0] e;
    while (mq.size() > 0) begin
      e = mq.pop_front();
      @(negedge clk);
      chk({req, " valid"}, 16'(q_valid), 16'h1);
      chk({req, " head"}, {7'd0, q_tag, q_data}, {7'd0, e});
      pop1();
    end
    @(negedge clk);
    chk({req, " empty"}, 16'(q_valid), 16'h0);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_aen = 1'b0; host_wr = 1'b0; host_rd = 1'b0; q_pop = 1'b0;
    host_addr = '0; host_wdata = '0; stat_in = '0; pd_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pd_out", 16'(pd_out), 16'h00);
    chk("R1 pd_oe", 16'(pd_oe), 16'h1);
    chk("R1 q_valid", 16'(q_valid), 16'h0);
    chk("R1 rdata", 16'(host_rdata), 16'h00);
    rd(16'h402, v); chk("R1 ecr", 16'(v), 16'h01);
    rd(16'h002, v); chk("R1 ctrl", 16'(v), 16'h00);
    data_exp = 8'h00; cfgb_exp = 8'h00;

    // sweep every mode over every offset
    for (int m = 0; m < 8; m++) begin
      wr(16'h402, 8'(m << 5));
      rd(16'h402, v); chk("R4 ecr mode", 16'(v), 16'((m << 5) | 1));
      wr(16'h002, 8'h0A ^ 8'(m));
      rd(16'h002, v); chk("R4 ctrl", 16'(v), 16'(8'h0A ^ 8'(m)));
      stat_in = 8'h50 + 8'(m);
      rd(16'h001, v); chk("R4 stat", 16'(v), 16'(stat_in));
      wr(16'h000, 8'h30 + 8'(m));
      if (m <= 1) data_exp = 8'h30 + 8'(m);
      if (m == 3) mq.push_back({1'b1, 8'h33});           // R5 tag 1
      @(negedge clk);
      chk("R3 pd_out", 16'(pd_out), 16'(data_exp));
      pd_in = 8'hA0 + 8'(m);
      rd(16'h000, v); chk("R3 R11 data read", 16'(v), (m <= 1) ? 16'(pd_in) : 16'h0);
      rd(16'h400, v); chk("R10 R11 hi read", 16'(v), (m == 7) ? 16'(CFGA) : 16'h0);
      wr(16'h400, 8'h60 + 8'(m));
      if (m == 2 || m == 3 || m == 6) mq.push_back({1'b0, 8'h60 + 8'(m)}); // R6
      if (m == 7) begin
        rd(16'h400, v); chk("R10 cfgA readonly", 16'(v), 16'(CFGA));
      end
      wr(16'h401, 8'h70 + 8'(m));
      if (m == 7) cfgb_exp = 8'h70 + 8'(m);
      rd(16'h401, v); chk("R10 R11 cfgB", 16'(v), (m == 7) ? 16'(cfgb_exp) : 16'h0);
      rd(16'h003, v); chk("R11 hole", 16'(v), 16'h0);
      rd(16'h403, v); chk("R11 hole hi", 16'(v), 16'h0);
      if (m == 6) begin
        rd(16'h400, v); chk("R9 test read", 16'(v), 16'h66);
        void'(mq.pop_front());
        @(negedge clk); chk("R9 empty", 16'(q_valid), 16'h0);
      end else begin
        drain("R6 R7 sweep");
      end
      chk("R13 oe", 16'(pd_oe), 16'h1);
    end

    // R2 address-enable blocks everything
    wr(16'h402, 8'h00);
    wr(16'h000, 8'h5C); data_exp = 8'h5C;
    host_aen = 1'b1;
    wr(16'h000, 8'hFF);
    wr(16'h402, 8'hE0);
    rd(16'h402, v); chk("R2 read blocked", 16'(v), 16'h0);
    host_aen = 1'b0;
    @(negedge clk); chk("R2 pd_out held", 16'(pd_out), 16'(data_exp));
    rd(16'h402, v); chk("R2 ecr held", 16'(v), 16'h01);

    // R5 reverse direction discards address writes; R13 pin direction
    wr(16'h402, 8'h60);
    wr(16'h002, 8'h20);
    wr(16'h000, 8'h77);
    @(negedge clk); chk("R5 reverse discard", 16'(q_valid), 16'h0);
    chk("R13 oe ecp", 16'(pd_oe), 16'h1);
    wr(16'h402, 8'h20);
    @(negedge clk); chk("R13 oe bidir rev", 16'(pd_oe), 16'h0);
    wr(16'h402, 8'h00);
    @(negedge clk); chk("R13 oe std", 16'(pd_oe), 16'h1);
    wr(16'h002, 8'h00);

    // R7 R8 fill to full, then one more
    wr(16'h402, 8'h60);
    for (int i = 0; i < 16; i++) begin
      if (i % 2 == 0) begin
        wr(16'h000, 8'(8'h80 + i)); mq.push_back({1'b1, 8'(8'h80 + i)});
      end else begin
        wr(16'h400, 8'(8'h80 + i)); mq.push_back({1'b0, 8'(8'h80 + i)});
      end
    end
    rd(16'h402, v); chk("R4 R8 full flag", 16'(v), 16'h62);
    @(negedge clk);
    host_addr = BASE + 16'h400; host_wdata = 8'hEE; host_wr = 1'b1;
    #1 chk("R8 drop flag", 16'(fifo_drop), 16'h1);
    @(negedge clk); host_wr = 1'b0;
    chk("R8 drop clears", 16'(fifo_drop), 16'h0);
    drain("R7 R8 order");

    // R12 enqueue and dequeue in the same cycle
    wr(16'h400, 8'h11); wr(16'h400, 8'h12); wr(16'h400, 8'h13);
    @(negedge clk);
    host_addr = BASE; host_wdata = 8'h14; host_wr = 1'b1; q_pop = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; q_pop = 1'b0;
    mq.push_back({1'b0, 8'h12}); mq.push_back({1'b0, 8'h13}); mq.push_back({1'b1, 8'h14});
    drain("R12 same cycle");

    // R9 test mode: peripheral pop ignored, host drains
    wr(16'h402, 8'hC0);
    wr(16'h400, 8'h21); wr(16'h400, 8'h22);
    pop1();
    @(negedge clk); chk("R9 q_pop ignored", 16'(q_data), 16'h21);
    rd(16'h400, v); chk("R9 first", 16'(v), 16'h21);
    rd(16'h400, v); chk("R9 second", 16'(v), 16'h22);
    rd(16'h400, v); chk("R9 empty read", 16'(v), 16'h00);

    // R14 held strobes act once
    wr(16'h402, 8'h40);
    @(negedge clk);
    host_addr = BASE + 16'h400; host_wdata = 8'h5A; host_wr = 1'b1;
    repeat (4) @(negedge clk);
    host_wr = 1'b0;
    mq.push_back({1'b0, 8'h5A});
    drain("R14 single push");
    wr(16'h402, 8'hC0);
    wr(16'h400, 8'h31); wr(16'h400, 8'h32);
    @(negedge clk);
    host_addr = BASE + 16'h400; host_rd = 1'b1;
    repeat (4) @(negedge clk);
    chk("R14 held read", 16'(host_rdata), 16'h31);
    host_rd = 1'b0;
    @(negedge clk); chk("R14 one pop", 16'(q_data), 16'h32);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule